// File: doc/BRIEF.md
# Cascadable Dual Pulse Accumulator

This block holds two 8-bit counters, each fed by its own pulse pin. Each pin passes through a two-flop synchronizer. Each clean rising edge on the pin adds one to the count. In split mode the two counters run apart from each other. In chained mode they act as one 16-bit accumulator: the upper byte steps only when the lower byte rolls over from 0xFF to 0x00.

Software reaches the block through a small register bus. Byte accesses reach each counter, and a single word access at offset 0 reads or loads both bytes in the same cycle. Separate byte reads can see the count change between them. A word read cannot. An overflow flag is set when the upper counter rolls over, and it stays set until software clears it by writing 1 to it. When the interrupt enable bit is on, the flag drives an interrupt request.

Top module: `pulse_accum_pair`

## Requirements
- R1: After reset, both counters, the control bits (run, chain, irq enable) and the overflow flag read 0, and `irq` is 0.
- R2: Each rising edge of a pulse pin is counted exactly once, however long the pin stays high. The new count is readable starting 3 clock edges after the pin is sampled high.
- R3: With chain=0 and run=1, the lower counter counts `pulse_lo` edges, the upper counter counts `pulse_hi` edges, and each wraps from 0xFF to 0x00 on its own. A wrap of the lower counter has no effect on the upper counter.
- R4: With chain=1 and run=1, only `pulse_lo` edges count. The upper counter increments when the lower counter wraps, so {upper, lower} counts as one 16-bit value. `pulse_hi` is ignored in this mode.
- R5: The overflow flag is set when the upper counter wraps from 0xFF to 0x00 by counting. In chained mode this is the 16-bit wrap from 0xFFFF to 0x0000. Once set, the flag stays set.
- R6: A write to offset 3 with bit 0 = 1 clears the flag. A write with bit 0 = 0 leaves it unchanged. If a clear and a new overflow fall in the same cycle, the overflow wins.
- R7: `irq` is high exactly when the flag is set and the irq enable bit (offset 2, bit 2) is 1.
- R8: With run=0 (offset 2, bit 0), pulses change neither counter nor the flag, and the counters hold their values.
- R9: When a write to a counter byte and a counting step for that byte fall in the same cycle, the written value is kept and the step is lost. In chained mode, a write to the lower byte also suppresses the carry into the upper byte.
- R10: At offset 0 with `bus_word`=1, a read returns {upper, lower} from the same cycle. A write loads upper from `bus_wdata[15:8]` and lower from `bus_wdata[7:0]` at one clock edge.
- R11: The register map is fixed. Offset 0 is the lower byte, offset 1 the upper byte, offset 2 the control register (bit0 run, bit1 chain, bit2 irq enable), and offset 3 the status register (bit0 overflow flag). Byte reads return the value zero-extended in `bus_rdata`, and byte writes use `bus_wdata[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pulse_lo | input | 1 | Pulse pin of the lower counter, asynchronous |
| pulse_hi | input | 1 | Pulse pin of the upper counter, asynchronous |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_word | input | 1 | Word access (16-bit at offset 0) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle. Stopped counters hold their values. An upper counter in split mode moves only on its own edge. The lower byte carries into the upper byte in chained mode. A byte write always wins over a count. The flag stays set until a clear. Carry timing around the 0xFF boundary, the full 16-bit wrap, the loss of a step to a colliding write, and the 3-cycle synchronizer latency seen at the bus are shown only by the bench. It sweeps start values and pulse counts in both modes and compares against arithmetic expectations.

// File: rtl/pulse_accum_pair.sv
module pulse_accum_pair (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pulse_lo,
  input  logic        pulse_hi,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_word,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq
);

  logic [2:0] sync_lo, sync_hi;
  logic [7:0] cnt_lo, cnt_hi;
  logic       run, chain, ien, ovf;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_lo <= '0;
      sync_hi <= '0;
    end else begin
      sync_lo <= {sync_lo[1:0], pulse_lo};
      sync_hi <= {sync_hi[1:0], pulse_hi};
    end

  wire edge_lo = sync_lo[1] & ~sync_lo[2];
  wire edge_hi = sync_hi[1] & ~sync_hi[2];

  wire wr_lo   = bus_wr && bus_addr == 2'd0;
  wire wr_hi   = bus_wr && ((bus_addr == 2'd1 && !bus_word) || (bus_addr == 2'd0 && bus_word));
  wire wr_ctl  = bus_wr && bus_addr == 2'd2;
  wire clr_ovf = bus_wr && bus_addr == 2'd3 && bus_wdata[0];

  wire inc_lo  = run && edge_lo && !wr_lo;
  wire inc_hi  = !wr_hi && (chain ? (inc_lo && cnt_lo == 8'hFF) : (run && edge_hi));
  wire ovf_set = inc_hi && cnt_hi == 8'hFF;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
      run    <= 1'b0;
      chain  <= 1'b0;
      ien    <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      if (wr_lo)       cnt_lo <= bus_wdata[7:0];
      else if (inc_lo) cnt_lo <= cnt_lo + 8'd1;
      if (wr_hi)       cnt_hi <= bus_word ? bus_wdata[15:8] : bus_wdata[7:0];
      else if (inc_hi) cnt_hi <= cnt_hi + 8'd1;
      if (wr_ctl) {ien, chain, run} <= bus_wdata[2:0];
      if (ovf_set)      ovf <= 1'b1;
      else if (clr_ovf) ovf <= 1'b0;
    end

  always_comb
    case (bus_addr)
      2'd0:    bus_rdata = bus_word ? {cnt_hi, cnt_lo} : {8'h00, cnt_lo};
      2'd1:    bus_rdata = {8'h00, cnt_hi};
      2'd2:    bus_rdata = {13'h0, ien, chain, run};
      default: bus_rdata = {15'h0, ovf};
    endcase

  assign irq = ovf & ien;

endmodule

module pulse_accum_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bus_addr,
  input logic       bus_wr,
  input logic       bus_word,
  input logic [7:0] wlo,
  input logic       run,
  input logic       chain,
  input logic       edge_lo,
  input logic       edge_hi,
  input logic [7:0] cnt_lo,
  input logic [7:0] cnt_hi,
  input logic       ovf
);
  wire any_cnt_wr = bus_wr && bus_addr[1] == 1'b0;
  wire clr        = bus_wr && bus_addr == 2'd3 && wlo[0];

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !any_cnt_wr |=> $stable(cnt_lo) && $stable(cnt_hi)); // R8
  AST_SPLIT_HI: assert property (@(posedge clk) disable iff (!rst_n)
    !chain && !edge_hi && !any_cnt_wr |=> $stable(cnt_hi)); // R3
  AST_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    chain && run && edge_lo && !bus_wr && cnt_lo == 8'hFF |=> cnt_lo == 8'h00 && cnt_hi == $past(cnt_hi) + 8'd1); // R4
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 2'd0 && !bus_word |=> cnt_lo == $past(wlo)); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !clr |=> ovf); // R5
endmodule

bind pulse_accum_pair pulse_accum_pair_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_word(bus_word),
  .wlo(bus_wdata[7:0]), .run(run), .chain(chain), .edge_lo(edge_lo), .edge_hi(edge_hi),
  .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf(ovf)
);

// File: tb/sim_pulse_accum_pair.sv
module sim_pulse_accum_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pulse_lo = 1'b0, pulse_hi = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_word = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pulse_accum_pair u0 (.*);

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic w, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_word = w; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic w, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_word = w;
    #1 d = bus_rdata;
  endtask

  task automatic pulses(input int n, input bit hi);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (hi) pulse_hi = 1'b1; else pulse_lo = 1'b1;
      repeat (5) @(negedge clk);
      pulse_hi = 1'b0; pulse_lo = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin rd(a[1:0], 1'b0, v); chk("R1 reset", v, 16'h0); end
    chk("R1 irq", {15'h0, irq}, 16'h0);

    // R11 control readback
    wr(2'd2, 1'b0, 16'h0005);
    rd(2'd2, 1'b0, v); chk("R11 ctrl", v, 16'h0005);

    // R2 latency: count appears 3 edges after sampled high, counted once
    @(negedge clk); pulse_lo = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_addr = 2'd0; bus_word = 1'b0; #1 chk("R2 before", bus_rdata, 16'h0000);
    @(negedge clk); #1 chk("R2 after", bus_rdata, 16'h0001);
    repeat (20) @(negedge clk);
    #1 chk("R2 held high once", bus_rdata, 16'h0001);
    pulse_lo = 1'b0; repeat (4) @(negedge clk);

    // R3 split sweep
    for (int s = 250; s < 256; s++)
      for (int k = 0; k < 4; k++) begin
        wr(2'd0, 1'b1, {8'h10, s[7:0]});
        pulses(k, 0);
        rd(2'd0, 1'b1, v);
        chk("R3 split lo", v, {8'h10, 8'(s + k)});
      end
    wr(2'd1, 1'b0, 16'h00FE);
    pulses(3, 1);
    rd(2'd1, 1'b0, v); chk("R3 split hi wrap", v, 16'h0001);
    rd(2'd3, 1'b0, v); chk("R5 split flag", v, 16'h0001);
    chk("R7 irq on", {15'h0, irq}, 16'h1);
    wr(2'd3, 1'b0, 16'h0000);
    rd(2'd3, 1'b0, v); chk("R6 write 0 keeps", v, 16'h0001);
    wr(2'd3, 1'b0, 16'h0001);
    rd(2'd3, 1'b0, v); chk("R6 clear", v, 16'h0000);
    chk("R7 irq off", {15'h0, irq}, 16'h0);

    // R4/R5 chained sweep
    wr(2'd2, 1'b0, 16'h0003);
    begin
      logic [15:0] starts [6] = '{16'h0000, 16'h00FF, 16'h01FE, 16'h7FFF, 16'hFF00, 16'hFFFE};
      for (int i = 0; i < 6; i++)
        for (int k = 0; k < 4; k++) begin
          logic [16:0] sum;
          wr(2'd3, 1'b0, 16'h0001);
          wr(2'd0, 1'b1, starts[i]);
          pulses(k, 0);
          pulses(1, 1);
          sum = {1'b0, starts[i]} + 17'(k);
          rd(2'd0, 1'b1, v); chk("R4 chained", v, sum[15:0]);
          rd(2'd3, 1'b0, v); chk("R5 chained flag", v, {15'h0, sum[16]});
        end
    end
    chk("R7 irq disabled", {15'h0, irq}, 16'h0);

    // R8 stopped
    wr(2'd2, 1'b0, 16'h0002);
    wr(2'd0, 1'b1, 16'h1234);
    pulses(2, 0); pulses(2, 1);
    rd(2'd0, 1'b1, v); chk("R8 hold", v, 16'h1234);

    // R9 collision: write lands in the increment cycle
    wr(2'd2, 1'b0, 16'h0001);
    wr(2'd0, 1'b0, 16'h0007);
    @(negedge clk); pulse_lo = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_addr = 2'd0; bus_word = 1'b0; bus_wdata = 16'h0040; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    repeat (3) @(negedge clk); pulse_lo = 1'b0; repeat (3) @(negedge clk);
    rd(2'd0, 1'b0, v); chk("R9 write wins", v, 16'h0040);
    pulses(1, 0);
    rd(2'd0, 1'b0, v); chk("R9 counts after", v, 16'h0041);

    // R9 chained: upper write vs carry
    wr(2'd2, 1'b0, 16'h0003);
    wr(2'd0, 1'b1, 16'hFFFF);
    wr(2'd3, 1'b0, 16'h0001);
    @(negedge clk); pulse_lo = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_addr = 2'd1; bus_word = 1'b0; bus_wdata = 16'h0033; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    repeat (3) @(negedge clk); pulse_lo = 1'b0; repeat (3) @(negedge clk);
    rd(2'd0, 1'b1, v); chk("R9 upper write beats carry", v, 16'h3300);
    rd(2'd3, 1'b0, v); chk("R9 no flag", v, 16'h0000);

    // R10 word vs bytes
    wr(2'd0, 1'b1, 16'hA55A);
    rd(2'd0, 1'b1, v); chk("R10 word", v, 16'hA55A);
    rd(2'd1, 1'b0, v); chk("R11 hi byte", v, 16'h00A5);
    rd(2'd0, 1'b0, v); chk("R11 lo byte", v, 16'h005A);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule